// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block models a single programmable logic cell of a lookup-table fabric. Two 4-input tables (F and G) each hold a 16-entry truth table. A 3-input table (H) combines the F result, the G result and one extra input. Two flip-flops and four select bits decide what the two cell outputs carry. One setting picks the source for each flip-flop. Another setting picks, for each output, the flip-flop or the unregistered signal that feeds it.

After reset the cell loads its 44 configuration bits serially, one bit per clock, while `cfg_en` is high. The cell then locks that configuration and raises `cfg_done`. From then on it acts as logic until the next reset. With this two-level arrangement the cell can build any 5-variable function, two 4-variable functions plus a 3-variable one, or some wider functions such as 9-input parity.

Top module: `lut_logic_cell`

## Requirements
- R1: A synchronous active-high `rst` clears both flip-flops, the bit count and `cfg_done`. After the reset edge both outputs read 0.
- R2: While `cfg_en` is high and fewer than 44 bits have been taken, each clock shifts in one bit of `cfg_din`. The first bit sent is F table bit 15. The bits arrive in this order: F table bits 15..0, G table bits 15..0, H table bits 7..0, then four select bits: X flip-flop source, Y flip-flop source, X output registered, Y output registered.
- R3: `cfg_done` rises on the clock edge after the edge that took the 44th bit. It then stays high until reset. After that, `cfg_en` and `cfg_din` have no effect on the cell's function.
- R4: Both outputs are 0 while `cfg_done` is low, whatever the data inputs are.
- R5: The F output is F table bit `in_f`, and the G output is G table bit `in_g`. In both cases the input bit 3 is the most significant bit of the index.
- R6: The H output is H table bit {`in_h1`, G output, F output}, with `in_h1` as the most significant bit.
- R7: The X path carries H when its source bit is 1 and F when it is 0. The Y path carries H when its source bit is 1 and G when it is 0.
- R8: When an output's registered bit is 1, that output shows its flip-flop. The flip-flop takes the path value on each clock edge once `cfg_done` is high. When the registered bit is 0, the output follows the path value with no clock delay.
- R9: The flip-flops hold their value on every edge where `cfg_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Shift enable for configuration loading |
| cfg_din | input | 1 | Serial configuration data, first bit is F table MSB |
| in_f | input | 4 | Index into the F table |
| in_g | input | 4 | Index into the G table |
| in_h1 | input | 1 | Extra H table input (index MSB) |
| out_x | output | 1 | Cell output X |
| out_y | output | 1 | Cell output Y |
| cfg_done | output | 1 | Configuration complete and locked |

## Verification
The bench loads a 9-input parity configuration and walks a vector table against it. It then loads an asymmetric multiplexer-style configuration whose tables and select bits would break under a reversed shift order. A design that reversed the bit order would light the wrong table entries or mix up the combinational and registered selections.

Several timing cases are checked directly:
- `cfg_done` is still low right after the 44th bit and rises one edge later; a done flag that came a cycle early or late fails here.
- Outputs stay at zero during the load even when the inputs would drive a 1.
- A registered output keeps its old value until the next edge.

Two further checks cover the locked configuration. Continued shifting after the lock must not change the cell's function, and a later reset must clear the outputs and the lock.

// File: rtl/lut_logic_cell.sv
module lut_logic_cell (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_en,
  input  logic       cfg_din,
  input  logic [3:0] in_f,
  input  logic [3:0] in_g,
  input  logic       in_h1,
  output logic       out_x,
  output logic       out_y,
  output logic       cfg_done
);
  localparam int FG_BITS  = 16;
  localparam int H_BITS   = 8;
  localparam int SEL_BITS = 4;
  localparam int CFG_BITS = 2 * FG_BITS + H_BITS + SEL_BITS;
  localparam int CW       = $clog2(CFG_BITS + 1);

  logic [CFG_BITS-1:0] cfg_sr;
  logic [CW-1:0]       cnt;
  logic                qx, qy;

  wire [FG_BITS-1:0] tbl_f = cfg_sr[CFG_BITS-1 -: FG_BITS];
  wire [FG_BITS-1:0] tbl_g = cfg_sr[CFG_BITS-FG_BITS-1 -: FG_BITS];
  wire [H_BITS-1:0]  tbl_h = cfg_sr[SEL_BITS +: H_BITS];
  wire sel_x_h   = cfg_sr[3];
  wire sel_y_h   = cfg_sr[2];
  wire sel_x_reg = cfg_sr[1];
  wire sel_y_reg = cfg_sr[0];

  wire f_o = tbl_f[in_f];
  wire g_o = tbl_g[in_g];
  wire h_o = tbl_h[{in_h1, g_o, f_o}];

  wire dx = sel_x_h ? h_o : f_o;
  wire dy = sel_y_h ? h_o : g_o;

  wire full = (cnt == CW'(CFG_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_sr   <= '0;
      cnt      <= '0;
      cfg_done <= 1'b0;
      qx       <= 1'b0;
      qy       <= 1'b0;
    end else begin
      if (cfg_en && !full) begin
        cfg_sr <= {cfg_sr[CFG_BITS-2:0], cfg_din};
        cnt    <= cnt + 1'b1;
      end
      cfg_done <= full;
      if (cfg_done) begin
        qx <= dx;
        qy <= dy;
      end
    end
  end

  assign out_x = cfg_done & (sel_x_reg ? qx : dx);
  assign out_y = cfg_done & (sel_y_reg ? qy : dy);
endmodule

// File: rtl/lut_logic_cell_chk.sv
module lut_logic_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_done,
  input logic       out_x,
  input logic       out_y,
  input logic       qx,
  input logic       qy,
  input logic [5:0] cnt
);
  localparam logic [5:0] LAST = 6'd44;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!cfg_done && !out_x && !out_y && !qx && !qy)); // R1

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> $past(cnt) == LAST); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> cfg_done); // R3

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |-> (!out_x && !out_y)); // R4

  AST_FF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |=> ($stable(qx) && $stable(qy))); // R9
endmodule

bind lut_logic_cell lut_logic_cell_chk chk_i (
  .clk(clk), .rst(rst), .cfg_done(cfg_done), .out_x(out_x), .out_y(out_y),
  .qx(qx), .qy(qy), .cnt(cnt)
);

// File: tb/lut_logic_cell_tb_top.sv
`timescale 1ns/1ps
module lut_logic_cell_tb_top;
  logic clk = 1'b0;
  logic rst, cfg_en, cfg_din, in_h1;
  logic [3:0] in_f, in_g;
  logic out_x, out_y, cfg_done;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lut_logic_cell dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .in_f(in_f), .in_g(in_g), .in_h1(in_h1),
    .out_x(out_x), .out_y(out_y), .cfg_done(cfg_done)
  );

  // parity config: F=par4, G=par4, H=par3, X from H comb, Y from G comb
  localparam logic [43:0] CFG_PAR = {16'h6996, 16'h6996, 8'h96, 4'b1000};
  // mux config: F=AND4, G=OR4, H = h1 ? g : f, X from H reg, Y from G reg
  localparam logic [43:0] CFG_MUX = {16'h8000, 16'hFFFE, 8'hCA, 4'b1011};

  // {in_f, in_g, in_h1, exp_x, exp_y} for CFG_PAR
  localparam logic [10:0] VEC [9] = '{
    {4'h0, 4'h0, 1'b0, 1'b0, 1'b0},
    {4'h1, 4'h0, 1'b0, 1'b1, 1'b0},
    {4'h0, 4'h1, 1'b0, 1'b1, 1'b1},
    {4'h3, 4'h0, 1'b1, 1'b1, 1'b0},
    {4'hF, 4'hF, 1'b1, 1'b1, 1'b0},
    {4'h7, 4'h1, 1'b0, 1'b0, 1'b1},
    {4'hE, 4'h8, 1'b1, 1'b1, 1'b1},
    {4'h5, 4'h6, 1'b0, 1'b0, 1'b0},
    {4'h2, 4'h4, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input logic [43:0] bits, input int nbits);
    for (int i = 43; i > 43 - nbits; i--) begin
      cfg_en = 1'b1; cfg_din = bits[i];
      @(posedge clk); @(negedge clk);
    end
    cfg_en = 1'b0; cfg_din = 1'b0;
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; cfg_en = 1'b0; cfg_din = 1'b0;
    in_f = 4'h1; in_g = 4'h0; in_h1 = 1'b0;
    step; step;
    chk("R1 reset done", cfg_done, 1'b0);
    chk("R1 reset x", out_x, 1'b0);
    chk("R1 reset y", out_y, 1'b0);
    rst = 1'b0;

    load(CFG_PAR, 43);
    chk("R4 gated x during load", out_x, 1'b0);
    load(CFG_PAR << 43, 1);
    chk("R3 done not yet after last bit", cfg_done, 1'b0);
    chk("R4 gated x before done", out_x, 1'b0);
    step;
    chk("R3 done one cycle later", cfg_done, 1'b1);

    for (int v = 0; v < 9; v++) begin
      in_f = VEC[v][10:7]; in_g = VEC[v][6:3]; in_h1 = VEC[v][2];
      #1;
      chk("R5 R6 R7 parity x", out_x, VEC[v][1]);
      chk("R5 R7 parity y", out_y, VEC[v][0]);
    end

    rst = 1'b1; step; rst = 1'b0;
    chk("R1 reset after use", cfg_done, 1'b0);
    in_f = 4'hF; in_g = 4'h0; in_h1 = 1'b0;
    load(CFG_MUX, 44);
    step;
    chk("R3 done second load", cfg_done, 1'b1);
    chk("R9 ff held during load x", out_x, 1'b0);
    step;
    chk("R8 registered x captured", out_x, 1'b1);
    chk("R8 registered y captured", out_y, 1'b0);
    in_f = 4'h0; in_g = 4'h1; #1;
    chk("R8 x waits for edge", out_x, 1'b1);
    chk("R8 y waits for edge", out_y, 1'b0);
    step;
    chk("R5 R7 x from F and", out_x, 1'b0);
    chk("R5 R7 y from G or", out_y, 1'b1);
    in_h1 = 1'b1; step;
    chk("R6 h1 selects g", out_x, 1'b1);
    in_g = 4'h0; in_f = 4'hF; step;
    chk("R6 h1 selects g low", out_x, 1'b0);
    in_g = 4'h2;
    for (int k = 0; k < 44; k++) begin
      cfg_en = 1'b1; cfg_din = k[0];
      step;
      chk("R3 locked x", out_x, 1'b1);
    end
    cfg_en = 1'b0;
    rst = 1'b1; step;
    chk("R1 sync reset x", out_x, 1'b0);
    chk("R1 sync reset y", out_y, 1'b0);
    chk("R1 sync reset done", cfg_done, 1'b0);
    rst = 1'b0;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule